// File: doc/BRIEF.md
# ADC Offset and Gain Calibration Unit

This unit follows the decimation stage of an oversampling converter and turns every raw signed 24-bit result into a corrected value. Two stored coefficients drive the correction: a zero-point value, subtracted from each sample, and a full-input value, which sets the span that is mapped onto a fixed target full scale. The arithmetic is done in wide signed form, divided with truncation toward zero and clamped to the signed output range.

The coefficients come from two calibration runs, started by a command. A zero-point run is made with no input applied. A full-input run is made with the maximum input applied. Each run averages a fixed number of raw samples and stores the mean. A full-input run is accepted only after a zero-point value exists. A host port can read and overwrite both coefficients, so saved values can be restored without a new run.

The unit also guards the amplifier-gain and oversampling-factor settings. Both are powers of two. A write whose product exceeds sixteen is refused, the old setting is kept, and a one-cycle error pulse is raised.

Top module: `adc_cal_unit`

## Requirements
- R1: After reset the zero-point coefficient is 0, the full-input coefficient is TGT_FS (4194304), both setting codes are 0, and busy, error and output valid are low.
- R2: A raw sample accepted while idle gives out_valid_o one cycle later. out_data_o is ((raw - zero) * TGT_FS) / (full - zero), truncated toward zero, using the coefficients held in the cycle the sample arrived.
- R3: A corrected value beyond the signed 24-bit range is clamped to 8388607 or -8388608.
- R4: When full - zero is zero or negative, out_data_o is raw - zero, clamped as in R3.
- R5: cal_start_i with cal_full_i = 0 starts a zero-point run. The next 8 valid raw samples are summed, and floor(sum / 8) is stored as the zero-point coefficient.
- R6: cal_start_i with cal_full_i = 1 starts a full-input run that averages the same way and stores the result as the full-input coefficient.
- R7: A full-input start is ignored until a zero-point run has completed or the zero-point coefficient has been written by the host. Any start is ignored while busy_o is high.
- R8: busy_o rises in the cycle after an accepted start and falls in the cycle after the 8th sample. A raw sample that arrives while busy_o is high produces no out_valid_o.
- R9: Gain code g and oversampling code t each stand for 2^code. A write with g <= 4, t <= 4 and g + t <= 4 updates gain_code_o and turbo_code_o in the next cycle.
- R10: A configuration write that breaks R9 leaves both codes unchanged and raises cfg_err_o for exactly the next cycle.
- R11: reg_we_i writes reg_wdata_i to the zero-point coefficient when reg_sel_i = 0 and to the full-input coefficient when reg_sel_i = 1. reg_rdata_o always shows the coefficient picked by reg_sel_i.
- R12: If a run stores into a coefficient in the same cycle the host writes that coefficient, the run's value is kept. A host write to the other coefficient in that cycle still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_valid_i | input | 1 | Raw sample strobe |
| raw_data_i | input | 24 | Raw signed sample |
| cal_start_i | input | 1 | Calibration run request |
| cal_full_i | input | 1 | Run kind: 0 zero-point, 1 full-input |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_gain_i | input | 3 | Requested gain code |
| cfg_turbo_i | input | 3 | Requested oversampling code |
| reg_we_i | input | 1 | Coefficient write strobe |
| reg_sel_i | input | 1 | Coefficient select |
| reg_wdata_i | input | 24 | Coefficient write data |
| reg_rdata_o | output | 24 | Selected coefficient |
| gain_code_o | output | 3 | Active gain code |
| turbo_code_o | output | 3 | Active oversampling code |
| cfg_err_o | output | 1 | Refused configuration pulse |
| busy_o | output | 1 | Calibration run in progress |
| out_valid_o | output | 1 | Corrected sample strobe |
| out_data_o | output | 24 | Corrected signed sample |

## Verification
Two events can land on the same clock edge. In the first, the store at the end of a run meets a host write, aimed either at the same coefficient or at the other one. In the second, a raw sample arrives on the edge where a start is accepted. The bench sets both up on purpose: it writes the zero-point coefficient on the edge of the 8th sample, and it starts a run on an edge that carries a sample. A behavioural model that follows the stated priority judges the stored coefficients and the output strobe on every clock. Random traffic repeats these overlaps further.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
  typedef enum logic {
    KIND_ZERO = 1'b0,
    KIND_FULL = 1'b1
  } cal_kind_e;
endpackage

// File: rtl/adc_cfg_guard.sv
module adc_cfg_guard #(
  parameter int CW      = 3,
  parameter int LIM_LOG = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [CW-1:0] gain_i,
  input  logic [CW-1:0] turbo_i,
  output logic [CW-1:0] gain_o,
  output logic [CW-1:0] turbo_o,
  output logic          err_o
);
  localparam logic [CW:0] LIM = (CW+1)'(LIM_LOG);

  logic [CW:0] sum;
  logic        legal;

  assign sum   = {1'b0, gain_i} + {1'b0, turbo_i};
  assign legal = ({1'b0, gain_i} <= LIM) && ({1'b0, turbo_i} <= LIM) && (sum <= LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_o  <= '0;
      turbo_o <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o <= we_i && !legal;
      if (we_i && legal) begin
        gain_o  <= gain_i;
        turbo_o <= turbo_i;
      end
    end
  end

  // R9: the active setting never breaks the product limit
  a_r9_setting_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, gain_o} + {1'b0, turbo_o}) <= LIM);
  // R10: a refusal leaves the setting untouched
  a_r10_err_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !legal |=> err_o && $stable(gain_o) && $stable(turbo_o));
endmodule

// File: rtl/adc_cal_seq.sv
module adc_cal_seq
  import adc_cal_pkg::*;
#(
  parameter int DW       = 24,
  parameter int AVG_LOG2 = 3,
  parameter int TGT_FS   = 1 << (DW - 2)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 raw_valid_i,
  input  logic signed [DW-1:0] raw_data_i,
  input  logic                 start_i,
  input  cal_kind_e            kind_i,
  input  logic                 reg_we_i,
  input  logic                 reg_sel_i,
  input  logic signed [DW-1:0] reg_wdata_i,
  output logic signed [DW-1:0] zero_o,
  output logic signed [DW-1:0] full_o,
  output logic                 busy_o
);
  localparam int AW = DW + AVG_LOG2;
  localparam logic [AVG_LOG2-1:0] LAST = '1;

  cal_kind_e            kind_q;
  logic                 zero_ok_q;
  logic [AVG_LOG2-1:0]  cnt_q;
  logic signed [AW-1:0] acc_q;
  logic signed [AW-1:0] acc_nx;
  logic signed [DW-1:0] mean;
  logic                 take, done, accept, st_zero, st_full;

  assign take    = busy_o && raw_valid_i;
  assign done    = take && (cnt_q == LAST);
  assign acc_nx  = acc_q + AW'(raw_data_i);
  assign mean    = DW'(acc_nx >>> AVG_LOG2);
  assign accept  = start_i && !busy_o && (kind_i == KIND_ZERO || zero_ok_q);
  assign st_zero = done && kind_q == KIND_ZERO;
  assign st_full = done && kind_q == KIND_FULL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o    <= 1'b0;
      kind_q    <= KIND_ZERO;
      zero_ok_q <= 1'b0;
      cnt_q     <= '0;
      acc_q     <= '0;
      zero_o    <= '0;
      full_o    <= DW'(TGT_FS);
    end else begin
      if (accept) begin
        busy_o <= 1'b1;
        kind_q <= kind_i;
        cnt_q  <= '0;
        acc_q  <= '0;
      end else if (take) begin
        cnt_q <= cnt_q + 1'b1;
        acc_q <= acc_nx;
        if (done) busy_o <= 1'b0;
      end
      // run store beats host write on the same coefficient
      if (st_zero) begin
        zero_o    <= mean;
        zero_ok_q <= 1'b1;
      end else if (reg_we_i && !reg_sel_i) begin
        zero_o    <= reg_wdata_i;
        zero_ok_q <= 1'b1;
      end
      if (st_full) full_o <= mean;
      else if (reg_we_i && reg_sel_i) full_o <= reg_wdata_i;
    end
  end

  // R7: a full-input run only ever starts once a zero point exists
  a_r7_full_after_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) && kind_q == KIND_FULL |-> zero_ok_q);
  // R8: busy ends exactly on the last averaged sample
  a_r8_busy_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !busy_o);
  // R12: the run's store wins over a host write to the same coefficient
  a_r12_store_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_zero |=> zero_o == $past(mean));
endmodule

// File: rtl/adc_corr_path.sv
module adc_corr_path #(
  parameter int DW     = 24,
  parameter int TGT_FS = 1 << (DW - 2)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic signed [DW-1:0] raw_i,
  input  logic signed [DW-1:0] zero_i,
  input  logic signed [DW-1:0] full_i,
  output logic                 valid_o,
  output logic signed [DW-1:0] data_o
);
  localparam int EW = 2 * DW + 2;
  localparam logic signed [EW-1:0] MAXV = EW'((64'sd1 <<< (DW - 1)) - 1);
  localparam logic signed [EW-1:0] MINV = -(MAXV + 1);

  logic signed [EW-1:0] diff, span, prod, quo, res;
  logic                 unity;

  assign diff  = EW'(raw_i) - EW'(zero_i);
  assign span  = EW'(full_i) - EW'(zero_i);
  assign unity = span <= 0;
  assign prod  = diff * EW'(TGT_FS);
  assign quo   = unity ? diff : prod / span;
  assign res   = (quo > MAXV) ? MAXV : (quo < MINV) ? MINV : quo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= en_i;
      if (en_i) data_o <= DW'(res);
    end
  end

  // R4: with no usable span the result is the plain difference, clamped
  a_r4_unity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && unity && diff <= MAXV && diff >= MINV |=> data_o == DW'($past(diff)));
  // R2: output strobe follows an accepted sample by one cycle
  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> valid_o);
endmodule

// File: rtl/adc_cal_unit.sv
module adc_cal_unit
  import adc_cal_pkg::*;
#(
  parameter int DW       = 24,
  parameter int CW       = 3,
  parameter int AVG_LOG2 = 3,
  parameter int LIM_LOG  = 4,
  parameter int TGT_FS   = 1 << (DW - 2)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 raw_valid_i,
  input  logic signed [DW-1:0] raw_data_i,
  input  logic                 cal_start_i,
  input  logic                 cal_full_i,
  input  logic                 cfg_we_i,
  input  logic [CW-1:0]        cfg_gain_i,
  input  logic [CW-1:0]        cfg_turbo_i,
  input  logic                 reg_we_i,
  input  logic                 reg_sel_i,
  input  logic signed [DW-1:0] reg_wdata_i,
  output logic signed [DW-1:0] reg_rdata_o,
  output logic [CW-1:0]        gain_code_o,
  output logic [CW-1:0]        turbo_code_o,
  output logic                 cfg_err_o,
  output logic                 busy_o,
  output logic                 out_valid_o,
  output logic signed [DW-1:0] out_data_o
);
  logic signed [DW-1:0] zero_q, full_q;
  cal_kind_e            kind;

  assign kind        = cal_full_i ? KIND_FULL : KIND_ZERO;
  assign reg_rdata_o = reg_sel_i ? full_q : zero_q;

  adc_cfg_guard #(.CW(CW), .LIM_LOG(LIM_LOG)) u_guard (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .gain_i  (cfg_gain_i),
    .turbo_i (cfg_turbo_i),
    .gain_o  (gain_code_o),
    .turbo_o (turbo_code_o),
    .err_o   (cfg_err_o)
  );

  adc_cal_seq #(.DW(DW), .AVG_LOG2(AVG_LOG2), .TGT_FS(TGT_FS)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .raw_valid_i (raw_valid_i),
    .raw_data_i  (raw_data_i),
    .start_i     (cal_start_i),
    .kind_i      (kind),
    .reg_we_i    (reg_we_i),
    .reg_sel_i   (reg_sel_i),
    .reg_wdata_i (reg_wdata_i),
    .zero_o      (zero_q),
    .full_o      (full_q),
    .busy_o      (busy_o)
  );

  adc_corr_path #(.DW(DW), .TGT_FS(TGT_FS)) u_corr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (raw_valid_i && !busy_o),
    .raw_i   (raw_data_i),
    .zero_i  (zero_q),
    .full_i  (full_q),
    .valid_o (out_valid_o),
    .data_o  (out_data_o)
  );

  // R8: samples taken during a run never reach the output
  a_r8_no_out_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && raw_valid_i |=> !out_valid_o);
  // R10: the error flag lasts a single cycle unless the next write is refused too
  a_r10_err_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o && !cfg_we_i |=> !cfg_err_o);
endmodule

// File: tb/adc_cal_unit_test.sv
module adc_cal_unit_test;
  localparam int CLK_P = 10;
  localparam int DW = 24;
  localparam longint TGT = 64'sd1 << (DW - 2);
  localparam longint MAXV = (64'sd1 << (DW - 1)) - 1;
  localparam longint MINV = -(64'sd1 << (DW - 1));

  logic clk = 0, rst_n = 0;
  logic raw_v = 0, cal_start = 0, cal_full = 0, cfg_we = 0, reg_we = 0, reg_sel = 0;
  logic signed [DW-1:0] raw_d = '0, reg_wd = '0;
  logic [2:0] cfg_g = '0, cfg_t = '0;
  logic signed [DW-1:0] rdata, odata;
  logic [2:0] gcode, tcode;
  logic cerr, busy, ovalid;

  int checks = 0, errors = 0;

  longint m_zero, m_full, m_acc;
  bit m_zok, m_busy, m_kind, m_err, m_ov;
  int m_cnt, m_g, m_t;
  longint m_od;

  adc_cal_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .raw_valid_i(raw_v), .raw_data_i(raw_d),
    .cal_start_i(cal_start), .cal_full_i(cal_full), .cfg_we_i(cfg_we),
    .cfg_gain_i(cfg_g), .cfg_turbo_i(cfg_t), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wd), .reg_rdata_o(rdata), .gain_code_o(gcode),
    .turbo_code_o(tcode), .cfg_err_o(cerr), .busy_o(busy),
    .out_valid_o(ovalid), .out_data_o(odata)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint corr(longint raw, longint z, longint f);
    longint d = raw - z, s = f - z, r;
    r = (s <= 0) ? d : (d * TGT) / s;
    if (r > MAXV) r = MAXV;
    if (r < MINV) r = MINV;
    return r;
  endfunction

  task automatic model_reset();
    m_zero = 0; m_full = TGT; m_acc = 0; m_zok = 0; m_busy = 0; m_kind = 0;
    m_err = 0; m_ov = 0; m_cnt = 0; m_g = 0; m_t = 0; m_od = 0;
  endtask

  task automatic compare();
    chk("R9/R10 gain", gcode, m_g);
    chk("R9/R10 turbo", tcode, m_t);
    chk("R10 err", cerr, m_err);
    chk("R8 busy", busy, m_busy);
    chk("R2/R8 valid", ovalid, m_ov);
    if (m_ov) chk("R2/R3/R4 data", odata, m_od);
    chk("R11 rdata", rdata, reg_sel ? m_full : m_zero);
  endtask

  // advance one clock: model next state from current inputs, then compare
  task automatic tick();
    longint n_zero = m_zero, n_full = m_full, n_acc = m_acc;
    bit n_zok = m_zok, n_busy = m_busy, n_kind = m_kind, st_z = 0, st_f = 0;
    int n_cnt = m_cnt, n_g = m_g, n_t = m_t;
    bit legal = (cfg_g <= 4) && (cfg_t <= 4) && (int'(cfg_g) + int'(cfg_t) <= 4);
    m_err = cfg_we && !legal;
    if (cfg_we && legal) begin n_g = cfg_g; n_t = cfg_t; end
    if (raw_v && !m_busy) m_od = corr(raw_d, m_zero, m_full);
    m_ov = raw_v && !m_busy;
    if (cal_start && !m_busy && (!cal_full || m_zok)) begin
      n_busy = 1; n_kind = cal_full; n_cnt = 0; n_acc = 0;
    end else if (m_busy && raw_v) begin
      n_acc = m_acc + longint'(raw_d);
      n_cnt = m_cnt + 1;
      if (m_cnt == 7) begin
        n_busy = 0; n_cnt = 0;
        if (m_kind) begin st_f = 1; n_full = n_acc >>> 3; end
        else begin st_z = 1; n_zero = n_acc >>> 3; n_zok = 1; end
      end
    end
    if (reg_we && !reg_sel && !st_z) begin n_zero = longint'(reg_wd); n_zok = 1; end
    if (reg_we && reg_sel && !st_f) n_full = longint'(reg_wd);
    @(posedge clk);
    #1;
    m_zero = n_zero; m_full = n_full; m_acc = n_acc; m_zok = n_zok; m_busy = n_busy;
    m_kind = n_kind; m_cnt = n_cnt; m_g = n_g; m_t = n_t;
    compare();
  endtask

  task automatic idle();
    raw_v = 0; cal_start = 0; cfg_we = 0; reg_we = 0;
  endtask

  task automatic sample(longint v);
    raw_v = 1; raw_d = DW'(v); tick(); raw_v = 0;
  endtask

  task automatic cfg(int g, int t);
    cfg_we = 1; cfg_g = 3'(g); cfg_t = 3'(t); tick(); cfg_we = 0;
  endtask

  task automatic start(bit full);
    cal_start = 1; cal_full = full; tick(); cal_start = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    #(CLK_P * 2 + 1);
    // R1 reset state
    chk("R1 busy", busy, 0); chk("R1 valid", ovalid, 0); chk("R1 err", cerr, 0);
    chk("R1 gain", gcode, 0); chk("R1 turbo", tcode, 0);
    reg_sel = 0; #1 chk("R1 zero", rdata, 0);
    reg_sel = 1; #1 chk("R1 full", rdata, TGT);
    rst_n = 1;
    @(negedge clk);
    tick();

    // R2 identity with reset coefficients
    sample(1000); sample(-5000); sample(MAXV); sample(MINV);

    // R7 full-input start before any zero point: ignored
    start(1); chk("R7 ignored", busy, 0); tick();

    // R9 / R10 configuration
    cfg(2, 2); cfg(3, 2); chk("R10 err pulse", cerr, 1); tick(); chk("R10 one cycle", cerr, 0);
    cfg(5, 0); cfg(4, 0); cfg(0, 4); cfg(1, 4); cfg(0, 0);

    // R5 zero-point run; a sample on the start edge is corrected normally
    raw_v = 1; raw_d = 24'sd77; cal_start = 1; cal_full = 0; tick(); cal_start = 0;
    chk("R8 busy rise", busy, 1);
    sample(100); sample(-3); tick(); sample(105);
    start(1); chk("R7 start while busy", busy, 1);
    sample(98); sample(110); sample(101); sample(99);
    // R12 host write to the zero point on the store edge loses; other write wins
    raw_v = 1; raw_d = 24'sd102; reg_we = 1; reg_sel = 0; reg_wd = 24'sd5555; tick();
    idle(); chk("R12 zero kept", rdata, m_zero);
    chk("R5 zero stored", rdata, (longint'(100 - 3 + 105 + 98 + 110 + 101 + 99 + 102)) >>> 3);
    chk("R8 busy fall", busy, 0);

    // R6 full-input run
    start(1);
    for (int i = 0; i < 8; i++) sample(2000000 + i * 13);
    reg_sel = 1; #1 chk("R6 full stored", rdata, m_full);

    // R2 / R3 corrected samples, saturating both sides
    sample(1000000); sample(-70000); sample(8000000); sample(-8000000); sample(m_zero);

    // R4 span zero then negative
    reg_we = 1; reg_sel = 1; reg_wd = DW'(m_zero); tick(); reg_we = 0;
    sample(12345); sample(MINV);
    reg_we = 1; reg_sel = 1; reg_wd = DW'(m_zero - 5); tick(); reg_we = 0;
    sample(-400); sample(MAXV);

    // R11 host restore of both coefficients
    reg_we = 1; reg_sel = 0; reg_wd = -24'sd200; tick();
    reg_sel = 1; reg_wd = 24'sd3000000; tick(); reg_we = 0;
    sample(400000);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom % 100;
      raw_v = ($urandom % 3) != 0;
      raw_d = DW'($urandom);
      if (r < 10) raw_d = DW'(m_zero + longint'($urandom % 64) - 32);
      cal_start = (r >= 95); cal_full = $urandom % 2;
      cfg_we = (r >= 85 && r < 90); cfg_g = 3'($urandom); cfg_t = 3'($urandom);
      reg_we = (r >= 80 && r < 83); reg_sel = $urandom % 2;
      reg_wd = DW'($urandom % 4000000);
      tick();
    end
    idle();
    tick();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule